// File: doc/BRIEF.md
# Bit-Level Pipelined Unsigned Array Multiplier

This block multiplies two unsigned N-bit operands and returns the full 2N-bit product. It is pipelined down to single lookup-level stages: each registered bit is computed from at most four bits held in the previous register stage. Carries are never passed sideways within a row. Each carry is registered at its next-higher weight and absorbed by the following row. The pipeline keeps a sum vector and a carry vector in carry-save form.

The first row adds the two lowest partial products. Each following row folds in one more partial product with a full adder per bit. The last N rows only merge the sum and carry vectors with half adders, until no carry is left. Operand bits that later rows still need are carried forward in delay registers, so every bit of one operand pair leaves the pipeline in the same cycle. The block accepts a new pair on every clock and returns the product 2N-1 cycles later, together with a valid flag. N must be at least 3.

Top module: `bitpipe_mul`

## Requirements
- R1: When `out_valid` is high, `product` equals the unsigned product of the `a` and `b` values that were accepted with that result.
- R2: An operand pair sampled with `in_valid` high at clock edge P appears on `product`, with `out_valid` high, right after clock edge P+2N-2. That is exactly 2N-1 cycles, for example 15 cycles at N=8 and 7 cycles at N=4.
- R3: A new pair can be accepted on every clock edge. Back-to-back inputs produce back-to-back results in the order the pairs were accepted.
- R4: An edge at which `in_valid` is low produces no result: `out_valid` is low in the matching output cycle 2N-1 cycles later.
- R5: While `rst_n` is low, `out_valid` is low. Pairs that were in flight when reset was asserted are discarded. After release, `out_valid` stays low until a newly accepted pair reaches the output.
- R6: Corner operands give exact results: zero times anything is 0, one times x is x, and all-ones times all-ones is 2^(2N) - 2^(N+1) + 1 (0xFE01 at N=8, 0xE1 at N=4).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | The operand pair on `a` and `b` is accepted at this edge |
| a | input | N | Multiplicand, unsigned |
| b | input | N | Multiplier, unsigned |
| out_valid | output | 1 | `product` holds a result this cycle |
| product | output | 2N | Unsigned product a*b |

## Verification
The assertions assume that `rst_n` is released synchronously to `clk`. They also assume that `a` and `b` carry known values in every cycle where `in_valid` is high, because the reference model captures the operands only on those edges. The stimulus changes inputs a quarter period after the rising edge, and it holds `a` and `b` at defined values even during bubble and reset cycles. The result is compared only in cycles where `out_valid` is high, since the product register keeps its old value while no result is due.

// File: rtl/bitpipe_mul_pkg.sv
package bitpipe_mul_pkg;

  // Cycles from operand capture to product register.
  function automatic int pipe_depth(input int n);
    return 2 * n - 1;
  endfunction

  // Start offset of the delay line for multiplier bit j (j >= 2).
  // Line j has j-1 taps, so the lines pack into a triangular vector.
  function automatic int tri_base(input int j);
    return ((j - 2) * (j - 1)) / 2;
  endfunction

endpackage

// File: rtl/bitpipe_mul_seed_row.sv
// First row: adds partial products 0 and 1 with one half adder per weight.
module bitpipe_mul_seed_row #(
  parameter int N = 8
) (
  input  logic             clk,
  input  logic             en,
  input  logic [N-1:0]     mcand_i,
  input  logic [1:0]       mplr_lo_i,
  output logic [2*N-1:0]   sum_o,
  output logic [2*N-1:0]   carry_o
);
  localparam int W = 2 * N;

  logic [W-1:0] pa, pb, sum_d, carry_d;

  always_comb begin
    pa = '0;
    pb = '0;
    for (int j = 0; j < N; j++) begin
      pa[j]   = mcand_i[j] & mplr_lo_i[0];
      pb[j+1] = mcand_i[j] & mplr_lo_i[1];
    end
    sum_d      = pa ^ pb;
    carry_d[0] = 1'b0;
    for (int w = 1; w < W; w++) begin
      carry_d[w] = pa[w-1] & pb[w-1];
    end
  end

  always_ff @(posedge clk) begin
    if (en) begin
      sum_o   <= sum_d;
      carry_o <= carry_d;
    end
  end

endmodule

// File: rtl/bitpipe_mul_add_row.sv
// Accumulating row K: full adder of sum, carry and partial product K per weight.
// Each output bit depends on sum[w], carry[w], one multiplicand bit and the
// multiplier bit K: four inputs.
module bitpipe_mul_add_row #(
  parameter int N = 8,
  parameter int K = 2
) (
  input  logic             clk,
  input  logic             en,
  input  logic [2*N-1:0]   sum_i,
  input  logic [2*N-1:0]   carry_i,
  input  logic [N-1:0]     mcand_i,
  input  logic             mplr_bit_i,
  output logic [2*N-1:0]   sum_o,
  output logic [2*N-1:0]   carry_o
);
  localparam int W = 2 * N;

  logic [W-1:0] pp, sum_d, carry_d;

  always_comb begin
    pp = '0;
    for (int j = 0; j < N; j++) begin
      pp[j+K] = mcand_i[j] & mplr_bit_i;
    end
    sum_d      = sum_i ^ carry_i ^ pp;
    carry_d[0] = 1'b0;
    for (int w = 1; w < W; w++) begin
      carry_d[w] = (sum_i[w-1] & carry_i[w-1]) |
                   (sum_i[w-1] & pp[w-1]) |
                   (carry_i[w-1] & pp[w-1]);
    end
  end

  always_ff @(posedge clk) begin
    if (en) begin
      sum_o   <= sum_d;
      carry_o <= carry_d;
    end
  end

endmodule

// File: rtl/bitpipe_mul_merge_row.sv
// Carry-resolve row: half adder per weight, the carry moves up one weight.
module bitpipe_mul_merge_row #(
  parameter int N = 8
) (
  input  logic             clk,
  input  logic             en,
  input  logic [2*N-1:0]   sum_i,
  input  logic [2*N-1:0]   carry_i,
  output logic [2*N-1:0]   sum_o,
  output logic [2*N-1:0]   carry_o
);
  localparam int W = 2 * N;

  logic [W-1:0] sum_d, carry_d;

  always_comb begin
    sum_d      = sum_i ^ carry_i;
    carry_d[0] = 1'b0;
    for (int w = 1; w < W; w++) begin
      carry_d[w] = sum_i[w-1] & carry_i[w-1];
    end
  end

  always_ff @(posedge clk) begin
    if (en) begin
      sum_o   <= sum_d;
      carry_o <= carry_d;
    end
  end

endmodule

// File: rtl/bitpipe_mul.sv
// Stage map (index = register stage):
//   0            seed row, partial products 0 and 1
//   1 .. N-2     add rows, partial product K = index+1
//   N-1 .. L-2   merge rows
//   L-1          final merge into the product register (L = 2N-1)
module bitpipe_mul
  import bitpipe_mul_pkg::*;
#(
  parameter int N = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [N-1:0]     a,
  input  logic [N-1:0]     b,
  output logic             out_valid,
  output logic [2*N-1:0]   product
);
  localparam int W    = 2 * N;
  localparam int LAT  = pipe_depth(N);
  localparam int NFWD = N - 2;
  localparam int BD   = tri_base(N);

  logic [LAT-1:0] vld_q, stage_en;
  logic [W-1:0]   sum_q [LAT-1];
  logic [W-1:0]   cry_q [LAT-1];
  logic [N-1:0]   mcand_d [NFWD];
  logic [N-1:0]   mcand_q [NFWD];
  logic [BD-1:0]  bdly_d, bdly_q, bdly_en;
  logic [W-1:0]   prod_d, prod_q;

  // Valid pipeline; stage k loads when the data entering it is valid.
  assign stage_en = {vld_q[LAT-2:0], in_valid};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= stage_en;
  end

  // Multiplicand delay registers, aligned with stages 0 .. N-3.
  for (genvar k = 0; k < NFWD; k++) begin : g_mcand
    if (k == 0) begin : g_head
      assign mcand_d[k] = a;
    end else begin : g_body
      assign mcand_d[k] = mcand_q[k-1];
    end
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < NFWD; k++) begin
      if (stage_en[k]) mcand_q[k] <= mcand_d[k];
    end
  end

  // Multiplier bit j travels j-1 stages until row K=j uses it.
  for (genvar j = 2; j < N; j++) begin : g_bline
    for (genvar d = 0; d < j - 1; d++) begin : g_tap
      localparam int IDX = tri_base(j) + d;
      if (d == 0) begin : g_head
        assign bdly_d[IDX] = b[j];
      end else begin : g_body
        assign bdly_d[IDX] = bdly_q[IDX-1];
      end
      assign bdly_en[IDX] = stage_en[d];
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < BD; i++) begin
      if (bdly_en[i]) bdly_q[i] <= bdly_d[i];
    end
  end

  bitpipe_mul_seed_row #(.N(N)) u_seed (
    .clk       (clk),
    .en        (stage_en[0]),
    .mcand_i   (a),
    .mplr_lo_i (b[1:0]),
    .sum_o     (sum_q[0]),
    .carry_o   (cry_q[0])
  );

  for (genvar s = 1; s <= N - 2; s++) begin : g_add
    bitpipe_mul_add_row #(.N(N), .K(s + 1)) u_add (
      .clk        (clk),
      .en         (stage_en[s]),
      .sum_i      (sum_q[s-1]),
      .carry_i    (cry_q[s-1]),
      .mcand_i    (mcand_q[s-1]),
      .mplr_bit_i (bdly_q[tri_base(s + 1) + s - 1]),
      .sum_o      (sum_q[s]),
      .carry_o    (cry_q[s])
    );
  end

  for (genvar s = N - 1; s <= LAT - 2; s++) begin : g_merge
    bitpipe_mul_merge_row #(.N(N)) u_merge (
      .clk     (clk),
      .en      (stage_en[s]),
      .sum_i   (sum_q[s-1]),
      .carry_i (cry_q[s-1]),
      .sum_o   (sum_q[s]),
      .carry_o (cry_q[s])
    );
  end

  // Last merge: every carry left lands at weight 2N or above, so only sums remain.
  assign prod_d = sum_q[LAT-2] ^ cry_q[LAT-2];

  always_ff @(posedge clk) begin
    if (stage_en[LAT-1]) prod_q <= prod_d;
  end

  assign out_valid = vld_q[LAT-1];
  assign product   = prod_q;

endmodule

// File: rtl/bitpipe_mul_chk.sv
module bitpipe_mul_chk
  import bitpipe_mul_pkg::*;
#(
  parameter int N = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_valid,
  input logic [N-1:0]   a,
  input logic [N-1:0]   b,
  input logic           out_valid,
  input logic [2*N-1:0] product
);
  localparam int W   = 2 * N;
  localparam int LAT = pipe_depth(N);
  localparam logic [W-1:0] OPMAX = {{N{1'b0}}, {N{1'b1}}};
  localparam logic [W-1:0] PMAX  = OPMAX * OPMAX;

  logic [LAT-1:0] ref_vld;
  logic [W-1:0]   ref_prod [LAT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ref_vld <= '0;
    else        ref_vld <= {ref_vld[LAT-2:0], in_valid};
  end

  always_ff @(posedge clk) begin
    ref_prod[0] <= {{N{1'b0}}, a} * {{N{1'b0}}, b};
    for (int i = 1; i < LAT; i++) ref_prod[i] <= ref_prod[i-1];
  end

  a_r1_product: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> product == ref_prod[LAT-1]);

  a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == ref_vld[LAT-1]);

  a_r5_reset_release: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !out_valid);

  a_r6_full_scale: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> product <= PMAX);

endmodule

bind bitpipe_mul bitpipe_mul_chk #(.N(N)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .a         (a),
  .b         (b),
  .out_valid (out_valid),
  .product   (product)
);

// File: tb/bitpipe_mul_test.sv
module bitpipe_mul_test;
  localparam int CLK_PERIOD = 10;
  localparam int LAT8 = 15;
  localparam int LAT4 = 7;

  typedef struct {
    int          due;
    logic [15:0] prod;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [7:0]  a8, b8;
  logic [3:0]  a4, b4;
  logic        ov8, ov4;
  logic [15:0] p8;
  logic [7:0]  p4;

  exp_t  q8[$];
  exp_t  q4[$];
  int    cyc = 0;
  int    checks = 0;
  int    errors = 0;
  bit    mon_on = 1'b0;
  bit    done = 1'b0;
  string idle_tag = "R5";

  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  bitpipe_mul #(.N(8)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .a(a8), .b(b8),
    .out_valid(ov8), .product(p8)
  );

  bitpipe_mul #(.N(4)) uut_n4 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .a(a4), .b(b4),
    .out_valid(ov4), .product(p4)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Driver: inputs change a quarter period after the rising edge.
  task automatic drive(input logic [7:0] av, input logic [7:0] bv,
                       input bit v, input string tag);
    exp_t e8, e4;
    @(posedge clk);
    #(CLK_PERIOD / 4);
    in_valid = v;
    a8 = av;
    b8 = bv;
    a4 = av[3:0];
    b4 = bv[3:0];
    if (v) begin
      e8.due = cyc + LAT8; e8.prod = 16'(av) * 16'(bv); e8.tag = tag;
      e4.due = cyc + LAT4; e4.prod = 16'(av[3:0]) * 16'(bv[3:0]); e4.tag = tag;
      q8.push_back(e8);
      q4.push_back(e4);
    end
  endtask

  task automatic do_reset(input int hold);
    @(posedge clk);
    #(CLK_PERIOD / 4);
    rst_n = 1'b0;
    in_valid = 1'b0;
    idle_tag = "R5";
    q8.delete();
    q4.delete();
    repeat (hold) @(posedge clk);
    #(CLK_PERIOD / 4);
    rst_n = 1'b1;
  endtask

  // Monitor: pops the expected result due in this cycle, or expects idle.
  always @(negedge clk) begin
    if (mon_on) begin
      if (q8.size() > 0 && q8[0].due == cyc) begin
        check(ov8 === 1'b1, "R2", "out_valid at due cycle N=8", {15'd0, ov8}, 16'd1);
        check(p8 === q8[0].prod, q8[0].tag, "product N=8", p8, q8[0].prod);
        void'(q8.pop_front());
      end else begin
        check(ov8 === 1'b0, idle_tag, "out_valid idle N=8", {15'd0, ov8}, 16'd0);
      end
      if (q4.size() > 0 && q4[0].due == cyc) begin
        check(ov4 === 1'b1, "R2", "out_valid at due cycle N=4", {15'd0, ov4}, 16'd1);
        check({8'd0, p4} === q4[0].prod, q4[0].tag, "product N=4", {8'd0, p4}, q4[0].prod);
        void'(q4.pop_front());
      end else begin
        check(ov4 === 1'b0, idle_tag, "out_valid idle N=4", {15'd0, ov4}, 16'd0);
      end
    end
  end

  task automatic report;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R2 watchdog expired: actual %0d expected %0d", 0, 1);
      report();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    in_valid = 1'b0;
    a8 = '0; b8 = '0; a4 = '0; b4 = '0;
    repeat (3) @(posedge clk);
    #(CLK_PERIOD / 4);
    rst_n = 1'b1;
    mon_on = 1'b1;
    // R5: idle after the first reset release
    repeat (4) drive(8'h00, 8'h00, 1'b0, "R5");
    idle_tag = "R4";

    // R6: corner operands, back to back
    drive(8'h00, 8'h00, 1'b1, "R6");
    drive(8'hFF, 8'hFF, 1'b1, "R6");
    drive(8'h00, 8'hFF, 1'b1, "R6");
    drive(8'hFF, 8'h00, 1'b1, "R6");
    drive(8'h01, 8'hFF, 1'b1, "R6");
    drive(8'hFF, 8'h01, 1'b1, "R6");
    drive(8'h01, 8'h01, 1'b1, "R6");
    drive(8'hFF, 8'hFF, 1'b1, "R6");

    // R1: walking ones against varied partners
    for (int i = 0; i < 8; i++) drive(8'(1 << i), 8'hA5 ^ 8'(i), 1'b1, "R1");
    for (int i = 0; i < 8; i++) drive(8'h5A, 8'(1 << i), 1'b1, "R1");

    // R3: back-to-back random stream
    for (int i = 0; i < 60; i++) drive(8'($urandom), 8'($urandom), 1'b1, "R3");

    // R4: bubbles interleaved with valid pairs
    for (int i = 0; i < 30; i++) drive(8'($urandom), 8'($urandom), (i % 3) != 0, "R1");
    for (int i = 0; i < 20; i++) drive(8'($urandom), 8'($urandom), (i % 2) == 0, "R1");

    // R5: reset with pairs in flight, which must be dropped
    for (int i = 0; i < 6; i++) drive(8'($urandom), 8'($urandom), 1'b1, "R3");
    do_reset(2);
    repeat (LAT8 + 3) drive(8'h33, 8'h77, 1'b0, "R5");
    idle_tag = "R4";

    for (int i = 0; i < 20; i++) drive(8'($urandom), 8'($urandom), 1'b1, "R1");
    repeat (LAT8 + 4) drive(8'h00, 8'h00, 1'b0, "R4");

    done = 1'b1;
    report();
    $finish;
  end

endmodule